// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous request port and an external asynchronous 64K x 16 static RAM. It accepts single-word read and write requests with a byte mask. It turns each request into a sequence of registered, active-low strobes: chip select, output enable, write enable and one enable per byte lane. The number of clock cycles in each phase comes from parameters. Read data comes back with a one-cycle valid pulse.

The memory data bus is split into a data output, an output-enable flag and a data input, so the pad ring can build the tristate outside. Output enable stays high for every write, so the memory never drives the bus while the controller does, and the write pulse needs no extra time for the bus to turn around. When a write follows a read, the controller inserts turnaround cycles with every strobe released before it drives the bus.

Top module: `bytelane_sram_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, chip select, output enable, write enable and both lane enables are high (1), and the data output enable is low.
- R2: `reqReady` is high only in the idle state. In that state every strobe is high and the data output enable is low.
- R3: A read drives chip select low, write enable high and output enable low. It drives the lane enable of lane i low only when `reqMask[i]` is 1. Lane 0 is bits 7:0 and lane 1 is bits 15:8. The data output enable stays low.
- R4: A read with a nonzero mask asserts `rspValid` for exactly one cycle. The pulse is seen 2 + RD_ACCESS clock edges after the accepting edge. `rspData` holds the memory word with every lane outside the mask forced to zero.
- R5: Write enable is low only while chip select is low and at least one lane enable is low. A write changes only the lanes whose mask bit is 1.
- R6: Output enable is high whenever write enable is low or the data output enable is high.
- R7: The address and the write data do not change on the cycle in which write enable rises, and the data output stays enabled on that cycle.
- R8: Write enable stays low for exactly WR_PULSE cycles. On the cycle before it falls, the data output is already enabled and chip select is already low.
- R9: After a read with a nonzero mask, the next write with a nonzero mask first spends TURN_CYC cycles with every strobe released. Its data output enable then rises TURN_CYC + 1 edges after the accepting edge. With no read in between, it rises 1 edge after.
- R10: A request with an all-zero mask asserts no strobe and returns to ready one edge after acceptance. A zero-mask read pulses `rspValid` with `rspData` = 0 on that edge, and a zero-mask write leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle; a request is taken on this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit i = 1 enables lane i |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 16 | Read data, lanes outside the mask are zero |
| memAddr | output | 16 | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBeN | output | 2 | Lane enables, active low, bit 0 = low byte |
| memDout | output | 16 | Data toward memory |
| memDoutEn | output | 1 | Drive memDout onto the bus |
| memDin | input | 16 | Data from memory |

## Verification
On every cycle, the assertions check the strobe rules. Write enable must never be low without chip select and a lane enable. Output enable must never be low while the controller drives the bus. Address and data must hold at the end of a write, and the data must be ready before write enable falls. The response valid signal must never stay high for two cycles.

Some behaviours only show up in the bench's scenarios, which sweep every mask over a range of addresses against a behavioural memory model. These are:
- which lanes a write actually changes, and the zeroing of lanes outside a read's mask;
- the exact read latency;
- the turnaround inserted only when a write follows a read;
- the no-op handling of zero-mask requests.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_TURNAROUND,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrlState_t;

  // Strobes for the next cycle, registered in the datapath
  typedef struct packed {
    logic selN;
    logic outEnN;
    logic wrEnN;
    logic laneActive;
    logic driveData;
    logic capture;
    logic zeroRsp;
    logic rspPulse;
    logic load;
  } strobe_t;

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int RD_ACCESS = 2,
  parameter int WR_PULSE  = 1,
  parameter int WR_RECOV  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    maskAny,
  output logic    reqReady,
  output strobe_t stbNext
);

  localparam int MAX_A = (RD_ACCESS > WR_PULSE) ? RD_ACCESS : WR_PULSE;
  localparam int MAX_B = (WR_RECOV > TURN_CYC) ? WR_RECOV : TURN_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_ACCESS - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_RECOV - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

  ctrlState_t state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic lastRead, nxtLastRead;
  logic cntDone;
  logic accept;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    nxtState    = state;
    nxtCnt      = cnt;
    nxtLastRead = lastRead;
    unique case (state)
      ST_IDLE: begin
        if (accept && maskAny) begin
          if (!reqWrite) begin
            nxtState    = ST_RD_SETUP;
            nxtLastRead = 1'b1;
          end else if (lastRead) begin
            nxtState = ST_TURNAROUND;
            nxtCnt   = TURN_LOAD;
          end else begin
            nxtState = ST_WR_SETUP;
          end
        end
      end
      ST_RD_SETUP: begin
        nxtState = ST_RD_WAIT;
        nxtCnt   = RD_LOAD;
      end
      ST_RD_WAIT: begin
        if (cntDone) nxtState = ST_RD_CAPTURE;
        else         nxtCnt   = cnt - 1'b1;
      end
      ST_RD_CAPTURE: nxtState = ST_IDLE;
      ST_TURNAROUND: begin
        if (cntDone) nxtState = ST_WR_SETUP;
        else         nxtCnt   = cnt - 1'b1;
      end
      ST_WR_SETUP: begin
        nxtState    = ST_WR_PULSE;
        nxtCnt      = WP_LOAD;
        nxtLastRead = 1'b0;
      end
      ST_WR_PULSE: begin
        if (cntDone) begin
          nxtState = ST_WR_RECOVER;
          nxtCnt   = WR_LOAD;
        end else begin
          nxtCnt = cnt - 1'b1;
        end
      end
      ST_WR_RECOVER: begin
        if (cntDone) nxtState = ST_IDLE;
        else         nxtCnt   = cnt - 1'b1;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  // Strobe decode from the next state, so the registered pins follow the state
  always_comb begin
    stbNext.selN       = !(nxtState inside {ST_RD_SETUP, ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE});
    stbNext.laneActive = !stbNext.selN;
    stbNext.outEnN     = (nxtState != ST_RD_WAIT);
    stbNext.wrEnN      = (nxtState != ST_WR_PULSE);
    stbNext.driveData  = nxtState inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
    stbNext.capture    = (state == ST_RD_WAIT) && cntDone;
    stbNext.zeroRsp    = accept && !maskAny && !reqWrite;
    stbNext.rspPulse   = stbNext.capture || stbNext.zeroRsp;
    stbNext.load       = accept && maskAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state    <= nxtState;
      cnt      <= nxtCnt;
      lastRead <= nxtLastRead;
    end
  end

endmodule

// File: rtl/bsram_datapath.sv
module bsram_datapath
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stbNext,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [LANES-1:0]  maskReg;
  logic [LANES-1:0]  maskNext;

  assign maskNext = stbNext.load ? reqMask : maskReg;
  assign memAddr  = addrReg;
  assign memDout  = wdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      wdataReg  <= '0;
      maskReg   <= '0;
      memCsN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memBeN    <= '1;
      memDoutEn <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      if (stbNext.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      maskReg   <= maskNext;
      memCsN    <= stbNext.selN;
      memOeN    <= stbNext.outEnN;
      memWeN    <= stbNext.wrEnN;
      memBeN    <= stbNext.laneActive ? ~maskNext : '1;
      memDoutEn <= stbNext.driveData;
      rspValid  <= stbNext.rspPulse;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rspData[i*8 +: 8] <= '0;
      end else if (stbNext.capture) begin
        rspData[i*8 +: 8] <= maskReg[i] ? memDin[i*8 +: 8] : 8'h00;
      end else if (stbNext.zeroRsp) begin
        rspData[i*8 +: 8] <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/bytelane_sram_ctrl.sv
module bytelane_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int RD_ACCESS = 2,
  parameter int WR_PULSE  = 1,
  parameter int WR_RECOV  = 1,
  parameter int TURN_CYC  = 1,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t stbNext;

  bsram_ctrl #(
    .RD_ACCESS(RD_ACCESS),
    .WR_PULSE (WR_PULSE),
    .WR_RECOV (WR_RECOV),
    .TURN_CYC (TURN_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .maskAny (|reqMask),
    .reqReady(reqReady),
    .stbNext (stbNext)
  );

  bsram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stbNext  (stbNext),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .memAddr  (memAddr),
    .memCsN   (memCsN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memBeN   (memBeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memDin   (memDin),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [LANES-1:0]  memBeN,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoutEn
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (memCsN && memOeN && memWeN && (&memBeN) && !memDoutEn));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memOeN && memWeN && (&memBeN) && !memDoutEn));

  p_read_enc_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCsN && memWeN && !(&memBeN) && !memDoutEn));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && !(&memBeN)));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || memDoutEn) |-> memOeN);

  p_write_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memAddr) && $stable(memDout) && memDoutEn));

  p_write_setup_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memDoutEn) && !$past(memCsN)));

endmodule

bind bytelane_sram_ctrl bytelane_sram_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memAddr  (memAddr),
  .memCsN   (memCsN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memBeN   (memBeN),
  .memDout  (memDout),
  .memDoutEn(memDoutEn)
);

// File: tb/bytelane_sram_ctrl_tb.sv
module bytelane_sram_ctrl_tb;

  localparam int RDA  = 2;
  localparam int WRP  = 1;
  localparam int WRR  = 1;
  localparam int TURN = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic [15:0] memAddr;
  logic        memCsN, memOeN, memWeN, memDoutEn;
  logic [1:0]  memBeN;
  logic [15:0] memDout;
  logic [15:0] memDin;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] model [256];
  logic [15:0] shadow [256];
  bit lastRead = 1'b0;

  always #5 clk = ~clk;

  bytelane_sram_ctrl #(
    .RD_ACCESS(RDA), .WR_PULSE(WRP), .WR_RECOV(WRR), .TURN_CYC(TURN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // Behavioural memory: reads drive enabled lanes, others carry junk
  always_comb begin
    logic [15:0] w;
    w = model[memAddr[7:0]];
    if (!memCsN && !memOeN && memWeN) begin
      memDin[7:0]  = memBeN[0] ? 8'hA5 : w[7:0];
      memDin[15:8] = memBeN[1] ? 8'hA5 : w[15:8];
    end else begin
      memDin = 16'hDEAD;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pin monitor and write commit
  bit prevAct = 1'b0, prevDoutEn = 1'b0, prevCsN = 1'b1;
  logic [15:0] pAddr, pData;
  logic [1:0]  pBe;
  int pulseLen = 0;

  always @(negedge clk) begin
    bit act;
    if (rstN) begin
      act = !memCsN && !memWeN && (memBeN != 2'b11);
      if (!memWeN) check(act && memOeN, "R5 R6 write gating", {memCsN, memOeN, memBeN}, 32'h4);
      if (memDoutEn) check(memOeN, "R6 oe high while driving", memOeN, 1);
      if (act) begin
        if (!prevAct) begin
          check(prevDoutEn && !prevCsN, "R8 setup before write pulse", {prevDoutEn, prevCsN}, 2'b10);
          pAddr = memAddr; pData = memDout; pBe = memBeN; pulseLen = 1;
        end else begin
          pulseLen++;
        end
      end else if (prevAct) begin
        check(memDoutEn && memAddr == pAddr && memDout == pData, "R7 hold at write end",
              {memAddr, memDout}, {pAddr, pData});
        check(pulseLen == WRP, "R8 pulse width", pulseLen, WRP);
        if (!pBe[0]) model[pAddr[7:0]][7:0]  = pData[7:0];
        if (!pBe[1]) model[pAddr[7:0]][15:8] = pData[15:8];
      end
      prevAct = act; prevDoutEn = memDoutEn; prevCsN = memCsN;
    end
  end

  // Issue one request; returns at the negedge after the accepting edge
  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    int cyc;
    int expCyc;
    issue(1'b1, a, d, m);
    if (m == 2'b00) begin
      check(memCsN && memWeN && !memDoutEn && reqReady, "R10 zero-mask write idle",
            {memCsN, memWeN, memDoutEn, reqReady}, 4'b1101);
      return;
    end
    expCyc = lastRead ? 1 + TURN : 1;
    cyc = 1;
    while (!memDoutEn && cyc < 50) begin
      if (!memCsN || !memOeN) check(1'b0, "R9 strobes released in turnaround", {memCsN, memOeN}, 2'b11);
      @(negedge clk); cyc++;
    end
    check(cyc == expCyc, "R9 data drive latency", cyc, expCyc);
    if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    lastRead = 1'b0;
    while (!reqReady) @(negedge clk);
  endtask

  task automatic doRead(input logic [15:0] a, input logic [1:0] m);
    int cyc;
    int expCyc;
    logic [15:0] exp;
    bit sawStrobe;
    issue(1'b0, a, 16'h0, m);
    cyc = 1;
    sawStrobe = 1'b0;
    while (!rspValid && cyc < 50) begin
      if (!memOeN) begin
        check(memBeN == ~m && !memCsN && memWeN, "R3 read strobe encoding",
              {memCsN, memWeN, memBeN}, {2'b01, ~m});
        sawStrobe = 1'b1;
      end
      @(negedge clk); cyc++;
    end
    exp[7:0]  = m[0] ? shadow[a[7:0]][7:0]  : 8'h00;
    exp[15:8] = m[1] ? shadow[a[7:0]][15:8] : 8'h00;
    if (m == 2'b00) begin
      check(cyc == 1 && rspData == 16'h0 && memCsN, "R10 zero-mask read", {cyc[15:0], rspData}, 32'h10000);
    end else begin
      expCyc = 2 + RDA;
      check(cyc == expCyc && sawStrobe, "R4 read latency", cyc, expCyc);
      check(rspData == exp, "R4 R5 read data lanes", rspData, exp);
      lastRead = 1'b1;
    end
    @(negedge clk);
    check(!rspValid, "R4 single valid pulse", rspValid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i]  = 16'(i * 16'h0105 + 16'h3C00);
      shadow[i] = 16'(i * 16'h0105 + 16'h3C00);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memCsN && memOeN && memWeN && memBeN == 2'b11 && !memDoutEn, "R1 reset pins",
          {memCsN, memOeN, memWeN, memBeN, memDoutEn}, 6'b111110);
    rstN = 1'b1;
    @(negedge clk);
    check(memCsN && memOeN && memWeN && memBeN == 2'b11 && !memDoutEn && reqReady, "R1 R2 after reset",
          {memCsN, memOeN, memWeN, memBeN, memDoutEn, reqReady}, 7'b1111101);

    // Sweep: every mask on every address, write then read back with every mask
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] addr;
        addr = 16'((a * 16'h1011) ^ (m << 12));
        addr[7:0] = 8'(a * 7 + 3);
        doWrite(addr, 16'(a * 16'h2B3D + m * 16'h1111), 2'(m));
        doWrite(addr, 16'(a * 16'h0707 + 16'h9000), 2'(3 - m));
        for (int rm = 0; rm < 4; rm++) doRead(addr, 2'(rm));
      end
    end

    // Back-to-back writes after a write (no turnaround), then full-word readback
    doWrite(16'h0042, 16'hBEEF, 2'b11);
    doWrite(16'h0043, 16'hCAFE, 2'b01);
    doWrite(16'h0042, 16'h1234, 2'b10);
    doRead(16'h0042, 2'b11);
    doRead(16'h0043, 2'b11);
    // Zero-mask write between read and write: must not cancel turnaround
    doWrite(16'h0043, 16'hFFFF, 2'b00);
    doWrite(16'h0044, 16'h5A5A, 2'b11);
    doRead(16'h0043, 2'b11);
    doRead(16'h0044, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule